// File: doc/BRIEF.md
# Panel Power Sequencer

This block steps an embedded display panel through power-up and power-down. Its supply-enable, powered and backlight outputs follow a requested power state, but only through a fixed sequence of states. After every power-down the block enforces a minimum off time before the supply may be raised again. That gap is programmed in coarse units: a one-cycle strobe, nominally every 100 ms, marks each unit. The encoded value is the gap in units plus one. A code of zero means "no gap", and it also aborts a gap that is being counted.

Once a power-up or power-down step has started, it runs to completion. A change of the request is acted on only when the step has finished. A force input holds the supply on whatever the sequence is doing. A reset-event input either walks the panel through the ordinary power-down or cuts the supply at once, depending on a mode bit. The current state code and a busy flag are exported for status reads.

Top module: `panel_pwr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters idle (state code 0), with `vdd_en`, `panel_on`, `bl_en` and `seq_busy` low and no gap pending. The first power-up after reset therefore starts without a gap.
- R2: `seq_state` reports the state with these codes: 0 idle, 1 gap with the request on, 2 power-up step, 3 on, 4 power-down step, 5 gap with the request off. `seq_busy` is high exactly in codes 1, 2, 4 and 5.
- R3: In idle, a high `pwr_target` moves the block to code 2 at the next edge, and `vdd_en` rises. The block leaves code 2 for code 3 at the first edge at which it has counted `up_ticks` ticks since entering. `panel_on` is high only in code 3.
- R4: In code 3, a low request moves the block to code 4, which drops `bl_en` while `vdd_en` stays high. The block enters code 5 once `down_ticks` ticks are counted. In code 5, `vdd_en` is low unless it is forced.
- R5: A nonzero `cycle_code` of N makes the gap end after N-1 ticks. Code 15 gives 14 ticks, and code 1 ends the gap at the first edge after entry.
- R6: A `cycle_code` of zero during a gap ends the gap at the next edge.
- R7: During a gap, the state tracks the request (code 1 when on, code 5 when off) without restarting the count. When the gap ends, the block goes to code 2 if the request is on and to code 0 if it is off.
- R8: A change of `pwr_target` during code 2 or code 4 does not alter that step. The step still ends only in its own successor state.
- R9: A high `vdd_force` holds `vdd_en` high in every state and leaves the state sequence untouched.
- R10: `bl_en` is high exactly when `bl_req` is high and the state is code 3.
- R11: With `pd_on_rst` high, a `rst_event` pulse in code 2, 3 or 4 makes the block finish any power-up step and run the normal power-down as though the request were off. Once the block reaches a gap, it follows `pwr_target` again.
- R12: With `pd_on_rst` low, a `rst_event` pulse in code 2, 3 or 4 moves the block to code 5 at the next edge, and the supply drops at once. A `rst_event` pulse in codes 0, 1 or 5 has no effect in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base strobe that advances all delay counts |
| pwr_target | input | 1 | Requested panel power state (1 on) |
| cycle_code | input | DLY_W | Power-cycle gap, encoded as units plus one; 0 means no gap |
| up_ticks | input | STEP_W | Ticks from supply enable to the powered state |
| down_ticks | input | STEP_W | Ticks from backlight drop to supply disable |
| vdd_force | input | 1 | Holds the supply enable high regardless of sequencing |
| bl_req | input | 1 | Backlight wanted when the panel is on |
| pd_on_rst | input | 1 | Reset events run the orderly power-down when high |
| rst_event | input | 1 | Reset event detected |
| vdd_en | output | 1 | Panel supply enable |
| panel_on | output | 1 | Panel is fully powered |
| bl_en | output | 1 | Backlight enable |
| seq_state | output | 3 | Current state code |
| seq_busy | output | 1 | A step or a gap is in progress |

## Verification
The sequence is driven first with a sparse tick (one every four cycles) and then with a tick on every cycle. The sparse tick tells "counted N ticks" apart from "waited N cycles". The dense tick pins the exact exit edge of the power-up step. Requests are flipped in the middle of each step and each gap. This separates a step that would be cut short from a gap that correctly switches between its two codes while keeping its count. Reset events are applied with the mode bit in both settings and in both powered and unpowered states, so the orderly walk-down, the abrupt cut and the ignored case each show up as a distinct state trace.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_GAP_UP    = 3'd1,
        ST_RAMP_UP   = 3'd2,
        ST_LIT       = 3'd3,
        ST_RAMP_DOWN = 3'd4,
        ST_GAP_DOWN  = 3'd5
    } pps_state_e;

    typedef struct packed {
        logic target;
        logic abrupt;
    } pps_req_t;

    function automatic logic is_rail_state(pps_state_e s);
        return (s == ST_RAMP_UP) || (s == ST_LIT) || (s == ST_RAMP_DOWN);
    endfunction

    function automatic logic is_gap_state(pps_state_e s);
        return (s == ST_GAP_UP) || (s == ST_GAP_DOWN);
    endfunction

    function automatic logic is_busy_state(pps_state_e s);
        return is_gap_state(s) || (s == ST_RAMP_UP) || (s == ST_RAMP_DOWN);
    endfunction

endpackage

// File: rtl/pps_tick_timer.sv
module pps_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    output logic [CNT_W-1:0] elapsed
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
        end else if (restart) begin
            elapsed <= '0;
        end else if (tick && (elapsed != CNT_MAX)) begin
            elapsed <= elapsed + 1'b1;
        end
    end
endmodule

// File: rtl/pps_reset_guard.sv
module pps_reset_guard
    import pps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_event,
    input  logic       pd_enable,
    input  pps_state_e state,
    output logic       pd_hold,
    output logic       abrupt
);
    always_comb begin
        abrupt = rst_event && !pd_enable && is_rail_state(state);
    end

    // An orderly power-down request persists until the rail is off.
    always_ff @(posedge clk) begin
        if (rst) begin
            pd_hold <= 1'b0;
        end else begin
            pd_hold <= (pd_hold || (rst_event && pd_enable)) && is_rail_state(state);
        end
    end
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
    import pps_pkg::*;
#(
    parameter int DLY_W  = 4,
    parameter int STEP_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  pps_req_t          req,
    input  logic [DLY_W-1:0]  cycle_code,
    input  logic [STEP_W-1:0] up_ticks,
    input  logic [STEP_W-1:0] down_ticks,
    input  logic [CNT_W-1:0]  elapsed,
    output pps_state_e        state,
    output logic              restart
);
    localparam int CW1 = CNT_W + 1;

    pps_state_e nxt;
    logic gap_done, up_done, down_done;

    always_comb begin
        // gap of code N lasts N-1 ticks; code 0 ends it immediately
        gap_done  = (cycle_code == '0) ||
                    ((CW1'(elapsed) + CW1'(1)) >= CW1'(cycle_code));
        up_done   = elapsed >= CNT_W'(up_ticks);
        down_done = elapsed >= CNT_W'(down_ticks);

        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req.target) nxt = ST_RAMP_UP;
            end
            ST_GAP_UP, ST_GAP_DOWN: begin
                if (gap_done) nxt = req.target ? ST_RAMP_UP : ST_IDLE;
                else          nxt = req.target ? ST_GAP_UP  : ST_GAP_DOWN;
            end
            ST_RAMP_UP: begin
                if (up_done) nxt = ST_LIT;
            end
            ST_LIT: begin
                if (!req.target) nxt = ST_RAMP_DOWN;
            end
            ST_RAMP_DOWN: begin
                if (down_done) nxt = ST_GAP_DOWN;
            end
            default: nxt = ST_IDLE;
        endcase

        if (req.abrupt) nxt = ST_GAP_DOWN;

        // moving between the two gap codes keeps the running count
        restart = (nxt != state) && !(is_gap_state(nxt) && is_gap_state(state));
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/pps_out_map.sv
module pps_out_map
    import pps_pkg::*;
(
    input  pps_state_e state,
    input  logic       vdd_force,
    input  logic       bl_req,
    output logic       vdd_en,
    output logic       panel_on,
    output logic       bl_en,
    output logic [2:0] seq_state,
    output logic       seq_busy
);
    always_comb begin
        vdd_en    = vdd_force || is_rail_state(state);
        panel_on  = (state == ST_LIT);
        bl_en     = bl_req && (state == ST_LIT);
        seq_state = state;
        seq_busy  = is_busy_state(state);
    end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import pps_pkg::*;
#(
    parameter int DLY_W  = 4,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              pwr_target,
    input  logic [DLY_W-1:0]  cycle_code,
    input  logic [STEP_W-1:0] up_ticks,
    input  logic [STEP_W-1:0] down_ticks,
    input  logic              vdd_force,
    input  logic              bl_req,
    input  logic              pd_on_rst,
    input  logic              rst_event,
    output logic              vdd_en,
    output logic              panel_on,
    output logic              bl_en,
    output logic [2:0]        seq_state,
    output logic              seq_busy
);
    localparam int CNT_W = (DLY_W > STEP_W) ? DLY_W : STEP_W;

    pps_state_e       state;
    pps_req_t         req;
    logic             pd_hold, abrupt, restart;
    logic [CNT_W-1:0] elapsed;

    always_comb begin
        req.target = pwr_target && !pd_hold;
        req.abrupt = abrupt;
    end

    pps_reset_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .rst_event (rst_event),
        .pd_enable (pd_on_rst),
        .state     (state),
        .pd_hold   (pd_hold),
        .abrupt    (abrupt)
    );

    pps_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick),
        .elapsed (elapsed)
    );

    pps_fsm #(.DLY_W(DLY_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .cycle_code (cycle_code),
        .up_ticks   (up_ticks),
        .down_ticks (down_ticks),
        .elapsed    (elapsed),
        .state      (state),
        .restart    (restart)
    );

    pps_out_map u_out (
        .state     (state),
        .vdd_force (vdd_force),
        .bl_req    (bl_req),
        .vdd_en    (vdd_en),
        .panel_on  (panel_on),
        .bl_en     (bl_en),
        .seq_state (seq_state),
        .seq_busy  (seq_busy)
    );
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
    parameter int DLY_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [DLY_W-1:0] cycle_code,
    input logic             vdd_force,
    input logic             bl_req,
    input logic             vdd_en,
    input logic             panel_on,
    input logic             bl_en,
    input logic [2:0]       seq_state
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (seq_state == 3'd0));

    p_powerup_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'd3) |=> ((seq_state == 3'd3) || (seq_state == 3'd4) || (seq_state == 3'd5)));

    p_gap_dark_r4: assert property (@(posedge clk) disable iff (rst)
        ((seq_state == 3'd5) && !vdd_force) |-> !vdd_en);

    p_zero_cancel_r6: assert property (@(posedge clk) disable iff (rst)
        (((seq_state == 3'd1) || (seq_state == 3'd5)) && (cycle_code == '0))
        |=> !((seq_state == 3'd1) || (seq_state == 3'd5)));

    p_step_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'd2) |=> ((seq_state == 3'd2) || (seq_state == 3'd3) || (seq_state == 3'd5)));

    p_force_vdd_r9: assert property (@(posedge clk) disable iff (rst)
        vdd_force |-> vdd_en);

    p_bl_gate_r10: assert property (@(posedge clk) disable iff (rst)
        bl_en |-> (panel_on && bl_req));
endmodule

bind panel_pwr_seq pps_checker #(.DLY_W(DLY_W)) u_pps_checker (
    .clk        (clk),
    .rst        (rst),
    .cycle_code (cycle_code),
    .vdd_force  (vdd_force),
    .bl_req     (bl_req),
    .vdd_en     (vdd_en),
    .panel_on   (panel_on),
    .bl_en      (bl_en),
    .seq_state  (seq_state)
);

// File: tb/panel_pwr_seq_test.sv
module panel_pwr_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       pwr_target = 1'b0;
    logic [3:0] cycle_code = 4'd4;
    logic [7:0] up_ticks = 8'd3;
    logic [7:0] down_ticks = 8'd2;
    logic       vdd_force = 1'b0;
    logic       bl_req = 1'b0;
    logic       pd_on_rst = 1'b0;
    logic       rst_event = 1'b0;
    logic       vdd_en, panel_on, bl_en, seq_busy;
    logic [2:0] seq_state;

    always #4 clk = ~clk;

    panel_pwr_seq uut (
        .clk(clk), .rst(rst), .tick(tick), .pwr_target(pwr_target),
        .cycle_code(cycle_code), .up_ticks(up_ticks), .down_ticks(down_ticks),
        .vdd_force(vdd_force), .bl_req(bl_req), .pd_on_rst(pd_on_rst),
        .rst_event(rst_event), .vdd_en(vdd_en), .panel_on(panel_on),
        .bl_en(bl_en), .seq_state(seq_state), .seq_busy(seq_busy)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // time base: one tick every tper cycles (tper 1 = every cycle)
    int tper = 4;
    int tcnt = 0;
    always @(negedge clk) begin
        tcnt++;
        tick <= (tper == 1) ? 1'b1 : ((tcnt % tper) == 0);
    end

    // behavioural reference: state number, tick count, orderly-down flag
    int m_st = 0, m_cnt = 0, m_pd = 0;
    always @(posedge clk) begin
        int nst, eff, rail;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_pd = 0;
        end else begin
            rail = (m_st == 2 || m_st == 3 || m_st == 4);
            eff  = pwr_target && !m_pd;
            nst  = m_st;
            if (m_st == 0 && eff) nst = 2;
            if (m_st == 1 || m_st == 5) begin
                if (cycle_code == 0 || m_cnt + 1 >= int'(cycle_code)) nst = eff ? 2 : 0;
                else nst = eff ? 1 : 5;
            end
            if (m_st == 2 && m_cnt >= int'(up_ticks)) nst = 3;
            if (m_st == 3 && !eff) nst = 4;
            if (m_st == 4 && m_cnt >= int'(down_ticks)) nst = 5;
            if (rail && rst_event && !pd_on_rst) nst = 5;
            m_pd = ((m_pd != 0) || (rst_event && pd_on_rst)) && rail;
            if (nst != m_st && !((nst == 1 || nst == 5) && (m_st == 1 || m_st == 5))) m_cnt = 0;
            else if (tick && m_cnt < 255) m_cnt++;
            m_st = nst;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(seq_state == 3'(m_st), "R2 R7 state", seq_state, m_st);
            chk(vdd_en == (vdd_force || m_st == 2 || m_st == 3 || m_st == 4), "R3 R9 vdd_en",
                vdd_en, (vdd_force || m_st == 2 || m_st == 3 || m_st == 4));
            chk(panel_on == (m_st == 3), "R3 panel_on", panel_on, (m_st == 3));
            chk(bl_en == (bl_req && m_st == 3), "R10 bl_en", bl_en, (bl_req && m_st == 3));
            chk(seq_busy == (m_st == 1 || m_st == 2 || m_st == 4 || m_st == 5), "R2 seq_busy",
                seq_busy, (m_st == 1 || m_st == 2 || m_st == 4 || m_st == 5));
        end
    end

    bit gap_count_on = 1'b0;
    int gap_ticks = 0;
    always @(posedge clk) begin
        if (gap_count_on && tick && (seq_state == 3'd1 || seq_state == 3'd5)) gap_ticks++;
    end

    task automatic wait_state(input int s, input string tag);
        for (int k = 0; k < 2000 && seq_state != 3'(s); k++) @(negedge clk);
        chk(seq_state == 3'(s), tag, seq_state, s);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(seq_state == 3'd0 && !vdd_en && !bl_en && !panel_on && !seq_busy, "R1 reset state", seq_state, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(seq_state == 3'd0, "R1 idle after reset", seq_state, 0);

        // R3: power-up from idle without a gap
        pwr_target = 1'b1;
        @(negedge clk);
        chk(seq_state == 3'd2 && vdd_en, "R3 power-up entered", seq_state, 2);
        wait_state(3, "R3 reach on");
        chk(panel_on, "R3 panel_on in on", panel_on, 1);

        // R10: backlight gating
        bl_req = 1'b1;
        @(negedge clk);
        chk(bl_en, "R10 backlight on", bl_en, 1);
        bl_req = 1'b0;
        @(negedge clk);
        chk(!bl_en, "R10 backlight off", bl_en, 0);
        bl_req = 1'b1;

        // R4 and R8: power-down with a request flip mid-step
        pwr_target = 1'b0;
        @(negedge clk);
        chk(seq_state == 3'd4 && !bl_en && vdd_en, "R4 power-down entered", seq_state, 4);
        pwr_target = 1'b1;
        @(negedge clk);
        chk(seq_state == 3'd4, "R8 step not interrupted", seq_state, 4);
        wait_state(1, "R7 gap with request on");
        wait_state(3, "R7 gap ends in power-up");

        // R5: code 15 counts 14 ticks
        cycle_code = 4'd15;
        gap_count_on = 1'b1;
        pwr_target = 1'b0;
        wait_state(5, "R4 gap after power-down");
        chk(!vdd_en, "R4 supply off in gap", vdd_en, 0);
        wait_state(0, "R7 gap ends in idle");
        gap_count_on = 1'b0;
        chk(gap_ticks == 14, "R5 gap length code 15", gap_ticks, 14);

        // R5: code 1 gives no gap
        cycle_code = 4'd1;
        pwr_target = 1'b1;
        wait_state(3, "R3 on again");
        pwr_target = 1'b0;
        wait_state(5, "R4 gap entered");
        @(negedge clk);
        chk(seq_state == 3'd0, "R5 code 1 immediate exit", seq_state, 0);

        // R6: zero cancels a running gap
        cycle_code = 4'd15;
        pwr_target = 1'b1;
        wait_state(3, "R1 first power-up style, no gap");
        pwr_target = 1'b0;
        wait_state(5, "R4 gap entered");
        repeat (2) @(negedge clk);
        cycle_code = 4'd0;
        @(negedge clk);
        chk(seq_state == 3'd0, "R6 zero cancels gap", seq_state, 0);

        // R9: forced supply in idle
        vdd_force = 1'b1;
        @(negedge clk);
        chk(vdd_en && seq_state == 3'd0, "R9 forced supply", vdd_en, 1);
        vdd_force = 1'b0;
        @(negedge clk);
        chk(!vdd_en, "R9 force released", vdd_en, 0);

        // R3: exact power-up length with a tick on every cycle
        tper = 1;
        up_ticks = 8'd5;
        pwr_target = 1'b1;
        wait_state(2, "R3 power-up dense tick");
        n = 0;
        while (seq_state == 3'd2 && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == 6, "R3 power-up cycles with up_ticks 5", n, 6);
        chk(seq_state == 3'd3, "R3 on after step", seq_state, 3);

        // R11: orderly power-down on reset event
        tper = 4;
        cycle_code = 4'd2;
        pd_on_rst = 1'b1;
        rst_event = 1'b1;
        @(negedge clk);
        rst_event = 1'b0;
        wait_state(4, "R11 orderly power-down started");
        wait_state(5, "R11 reaches gap");
        wait_state(3, "R11 request honoured again");

        // R12: abrupt cut on reset event
        pd_on_rst = 1'b0;
        rst_event = 1'b1;
        @(negedge clk);
        rst_event = 1'b0;
        chk(seq_state == 3'd5 && !vdd_en, "R12 abrupt cut", seq_state, 5);
        pwr_target = 1'b0;
        wait_state(0, "R12 back to idle");
        rst_event = 1'b1;
        @(negedge clk);
        rst_event = 1'b0;
        pd_on_rst = 1'b1;
        @(negedge clk);
        chk(seq_state == 3'd0 && !vdd_en, "R12 no effect in idle", seq_state, 0);
        rst_event = 1'b1;
        @(negedge clk);
        rst_event = 1'b0;
        repeat (2) @(negedge clk);
        chk(seq_state == 3'd0 && !vdd_en, "R12 no effect in idle, orderly mode", seq_state, 0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule